// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This unit is the final stage of a single-precision floating-point datapath. An arithmetic stage hands it a sign, a signed unbiased exponent and a 27-bit normalized significand: the hidden bit at bit 26, then 23 fraction bits, then three extra low-order bits (guard, round, sticky) at bits 2..0. The unit applies the selected rounding mode and produces the packed 32-bit encoding (sign in bit 31, biased exponent in bits 30..23, fraction in bits 22..0) together with inexact, underflow and overflow flags.

It covers denormalizing shifts for results below the normal range, renormalization when rounding carries out of the significand, saturation on overflow to infinity or to the largest finite value depending on mode, and an optional flush of tiny results. A result whose exponent is exactly one below the minimum, and which rounding lifts into the normal range, is treated as not tiny. The input significand is assumed normalized (bit 26 set). Operands that are NaN or exactly zero are not presented to this unit. The result and flags are registered. They appear one clock after a cycle with `inValid` high.

Top module: `rp_round_pack`

## Requirements
- R1: An input with bits 2..0 clear and exponent in [-126, 127] yields {sign, exponent+127, inSig[25:3]} with all three flags low.
- R2: Rounding mode encoding is 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. In nearest-even, when bits 2..0 are nonzero, the significand is increased by 4 if bit 3 is set and by 3 otherwise. An exact tie therefore rounds to an even fraction.
- R3: Toward zero never increments. Toward +infinity adds 8 (one fraction LSB) only to positive inexact results. Toward -infinity adds 8 only to negative inexact results.
- R4: `outInexact` is high exactly when, after any denormalizing shift, bits 2..0 of the significand are nonzero. It is also high in the R9 case and whenever R6 or R10 applies.
- R5: When rounding carries out of bit 26, the significand is shifted right by one and the exponent increases by one. For example, an all-ones fraction rounded up becomes the next power of two.
- R6: If the exponent after rounding exceeds 127, `outOverflow` and `outInexact` rise. The result is infinity for nearest-even. For toward zero it is the largest finite value of the same sign. Toward +infinity gives +infinity for positive results and -max for negative results. Toward -infinity gives +max for positive results and -infinity for negative results.
- R7: With flush off, an exponent below -126 (outside R9) shifts the significand right by -126 minus the exponent. Shifted-out bits are ORed into bit 0 and the exponent becomes -126. The result is encoded with exponent field 0, or with field 1 if rounding carried into the hidden bit.
- R8: `outUnderflow` is high when the result is inexact and bit 26 is clear before rounding (and R10 is not active).
- R9: With flush off, exponent -127, and rounding of the unshifted significand carrying out of bit 26, the result is the smallest normal number (field 1, fraction 0). Only `outInexact` is raised.
- R10: With `flushEn` high and exponent below -126, `outUnderflow` and `outInexact` rise. The result is signed zero in modes 0 and 1. In mode 2 the result is +smallest subnormal (0x00000001) for positive results and -0 for negative results. In mode 3 it is -smallest subnormal (0x80000001) for negative results and +0 for positive results.
- R11: Outputs are registered. `outValid` equals `inValid` of the previous cycle, and reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input operands are valid this cycle |
| inSign | input | 1 | Sign of the result |
| inExp | input | 10 | Signed unbiased exponent |
| inSig | input | 27 | Normalized significand with three extra low bits |
| roundMode | input | 2 | Rounding mode (0 nearest-even, 1 zero, 2 up, 3 down) |
| flushEn | input | 1 | Flush tiny results instead of encoding subnormals |
| outValid | output | 1 | Registered result is valid |
| outWord | output | 32 | Packed single-precision result |
| outInexact | output | 1 | Result was rounded |
| outUnderflow | output | 1 | Tiny and inexact result |
| outOverflow | output | 1 | Result exceeded the finite range |

## Verification
The bench targets the rounding ties and the all-ones fractions that carry through the whole significand. A wrong nearest-even increment would round ties up rather than to even. A missed renormalization would leave the exponent one short or drop the leading bit. At exponent -127 it separates the carry case, which must give the smallest normal with no underflow, from the truncating modes, which must give a subnormal with underflow. A design that tested tininess after shifting would wrongly raise underflow in the carry case. It checks every mode's overflow and flush encodings at both signs, where a swapped mode decode would return infinity in place of the largest finite value, or zero in place of the smallest subnormal. A reference model in the bench sweeps the exponents -150, -127, -126, 0, 127 and 128 across all modes and both flush settings.

// File: rtl/rp_pkg.sv
package rp_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } roundMode_e;

  // Decisions from control to datapath
  typedef struct packed {
    logic belowMin;    // exponent under the normal range
    logic useFlush;    // replace the result with the flush value
    logic nearest;     // nearest-even increment rule
    logic dirUp;       // directed mode rounding away from zero
    logic satToInf;    // overflow saturates to infinity
    logic flushToMin;  // flush gives smallest subnormal, not zero
  } rpStrobe_t;

endpackage

// File: rtl/rp_ctrl.sv
module rp_ctrl
  import rp_pkg::*;
#(
  parameter int EXP_W    = 10,
  parameter int EXP_BITS = 8
) (
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] expIn,
  input  logic [1:0]              mode,
  input  logic                    flushEn,
  output rpStrobe_t               strobe
);
  localparam int BIAS = (1 << (EXP_BITS - 1)) - 1;
  localparam int XW   = EXP_W + 2;
  localparam logic signed [XW-1:0] EMIN_X = XW'(1 - BIAS);

  roundMode_e modeE;
  logic signed [XW-1:0] expWide;
  logic below;
  logic awayUp;

  always_comb begin
    modeE   = roundMode_e'(mode);
    expWide = XW'(expIn);
    below   = expWide < EMIN_X;
    awayUp  = ((modeE == RM_UP) && !sign) || ((modeE == RM_DOWN) && sign);
    strobe.belowMin   = below;
    strobe.useFlush   = below && flushEn;
    strobe.nearest    = (modeE == RM_NEAREST);
    strobe.dirUp      = awayUp;
    strobe.satToInf   = (modeE == RM_NEAREST) || awayUp;
    strobe.flushToMin = awayUp;
  end

endmodule

// File: rtl/rp_datapath.sv
module rp_datapath
  import rp_pkg::*;
#(
  parameter int EXP_W    = 10,
  parameter int EXP_BITS = 8,
  parameter int FRAC_W   = 23
) (
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] expIn,
  input  logic [FRAC_W+3:0]       sigIn,
  input  rpStrobe_t               strobe,
  output logic [EXP_BITS+FRAC_W:0] word,
  output logic                    inexact,
  output logic                    underflow,
  output logic                    overflow
);
  localparam int SIG_W = FRAC_W + 4;
  localparam int BIAS  = (1 << (EXP_BITS - 1)) - 1;
  localparam int XW    = EXP_W + 2;
  localparam int SH_W  = $clog2(SIG_W + 1);
  localparam logic signed [XW-1:0] EMIN_X = XW'(1 - BIAS);
  localparam logic signed [XW-1:0] EMAX_X = XW'(BIAS);
  localparam logic signed [XW-1:0] BIAS_X = XW'(BIAS);

  function automatic logic [SIG_W:0] roundSig(input logic [SIG_W-1:0] s,
                                              input logic nr, input logic up);
    logic [3:0] inc;
    inc = 4'd0;
    if (|s[2:0]) begin
      if (nr) inc = s[3] ? 4'd4 : 4'd3;
      else if (up) inc = 4'd8;
    end
    return {1'b0, s} + (SIG_W + 1)'(inc);
  endfunction

  logic signed [XW-1:0] expWide, shiftAmt, stageExp, finalExp;
  logic [SIG_W:0]       rawRounded, postRounded;
  logic [SIG_W-1:0]     lostMask, denormSig, stageSig, finalSig;
  logic [SH_W-1:0]      shSmall;
  logic                 boundaryHit, stageInexact, tinyPre, expOver;
  logic [FRAC_W:0]      mant;
  logic [EXP_BITS-1:0]  expField;

  always_comb begin
    expWide    = XW'(expIn);
    rawRounded = roundSig(sigIn, strobe.nearest, strobe.dirUp);
    boundaryHit = strobe.belowMin && !strobe.useFlush &&
                  (expWide == EMIN_X - XW'(1)) && rawRounded[SIG_W];

    // sticky right shift into the subnormal range
    shiftAmt = EMIN_X - expWide;
    shSmall  = shiftAmt[SH_W-1:0];
    lostMask = ~({SIG_W{1'b1}} << shSmall);
    if (shiftAmt >= XW'(SIG_W)) begin
      denormSig = {{(SIG_W-1){1'b0}}, |sigIn};
    end else begin
      denormSig = (sigIn >> shSmall);
      denormSig[0] = denormSig[0] | (|(sigIn & lostMask));
    end

    if (boundaryHit) begin
      stageSig = rawRounded[SIG_W:1] & ~(SIG_W'(7));
      stageExp = EMIN_X;
    end else if (strobe.belowMin) begin
      stageSig = denormSig;
      stageExp = EMIN_X;
    end else begin
      stageSig = sigIn;
      stageExp = expWide;
    end

    stageInexact = |stageSig[2:0];
    tinyPre      = stageInexact && !stageSig[SIG_W-1];
    postRounded  = roundSig(stageSig, strobe.nearest, strobe.dirUp);
    if (postRounded[SIG_W]) begin
      finalSig = postRounded[SIG_W:1];
      finalExp = stageExp + XW'(1);
    end else begin
      finalSig = postRounded[SIG_W-1:0];
      finalExp = stageExp;
    end
    mant     = finalSig[SIG_W-1:3];
    expOver  = finalExp > EMAX_X;
    expField = mant[FRAC_W] ? EXP_BITS'(finalExp + BIAS_X) : '0;

    if (strobe.useFlush) begin
      word      = {sign, {(EXP_BITS+FRAC_W-1){1'b0}}, strobe.flushToMin};
      inexact   = 1'b1;
      underflow = 1'b1;
      overflow  = 1'b0;
    end else if (expOver) begin
      word      = strobe.satToInf ? {sign, {EXP_BITS{1'b1}}, {FRAC_W{1'b0}}}
                                  : {sign, {(EXP_BITS-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      inexact   = 1'b1;
      underflow = 1'b0;
      overflow  = 1'b1;
    end else begin
      word      = {sign, expField, mant[FRAC_W-1:0]};
      inexact   = stageInexact || boundaryHit;
      underflow = tinyPre;
      overflow  = 1'b0;
    end
  end

endmodule

// File: rtl/rp_round_pack.sv
module rp_round_pack
  import rp_pkg::*;
#(
  parameter int EXP_W    = 10,
  parameter int EXP_BITS = 8,
  parameter int FRAC_W   = 23
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic                      inSign,
  input  logic signed [EXP_W-1:0]   inExp,
  input  logic [FRAC_W+3:0]         inSig,
  input  logic [1:0]                roundMode,
  input  logic                      flushEn,
  output logic                      outValid,
  output logic [EXP_BITS+FRAC_W:0]  outWord,
  output logic                      outInexact,
  output logic                      outUnderflow,
  output logic                      outOverflow
);
  rpStrobe_t strobe;
  logic [EXP_BITS+FRAC_W:0] nextWord;
  logic nextInexact, nextUnderflow, nextOverflow;

  rp_ctrl #(.EXP_W(EXP_W), .EXP_BITS(EXP_BITS)) u_ctrl (
    .sign(inSign), .expIn(inExp), .mode(roundMode), .flushEn(flushEn),
    .strobe(strobe)
  );

  rp_datapath #(.EXP_W(EXP_W), .EXP_BITS(EXP_BITS), .FRAC_W(FRAC_W)) u_dpath (
    .sign(inSign), .expIn(inExp), .sigIn(inSig), .strobe(strobe),
    .word(nextWord), .inexact(nextInexact), .underflow(nextUnderflow),
    .overflow(nextOverflow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outWord      <= '0;
      outInexact   <= 1'b0;
      outUnderflow <= 1'b0;
      outOverflow  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outWord      <= nextWord;
        outInexact   <= nextInexact;
        outUnderflow <= nextUnderflow;
        outOverflow  <= nextOverflow;
      end
    end
  end

endmodule

// File: rtl/rp_round_pack_chk.sv
module rp_round_pack_chk #(
  parameter int EXP_W    = 10,
  parameter int EXP_BITS = 8,
  parameter int FRAC_W   = 23
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      inValid,
  input logic signed [EXP_W-1:0]   inExp,
  input logic [FRAC_W+3:0]         inSig,
  input logic                      flushEn,
  input logic                      outValid,
  input logic [EXP_BITS+FRAC_W:0]  outWord,
  input logic                      outInexact,
  input logic                      outUnderflow,
  input logic                      outOverflow
);
  localparam int BIAS = (1 << (EXP_BITS - 1)) - 1;
  localparam int TOP  = EXP_BITS + FRAC_W - 1;
  localparam logic [EXP_BITS-1:0] EXP_ONES = '1;
  localparam logic [EXP_BITS-1:0] EXP_MAXF = EXP_ONES - 1'b1;

  // R11: valid latency of one cycle
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R6: overflow comes with inexact and a saturated encoding
  a_r6_ovf_inexact: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outOverflow |-> outInexact && !outUnderflow);
  a_r6_ovf_encoding: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outOverflow |->
      (outWord[TOP:FRAC_W] == EXP_ONES && outWord[FRAC_W-1:0] == '0) ||
      (outWord[TOP:FRAC_W] == EXP_MAXF && outWord[FRAC_W-1:0] == '1));

  // R8: underflow is never reported on an exact result
  a_r8_unf_inexact: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outUnderflow |-> outInexact);

  // R10: flush yields zero or the smallest subnormal with both flags
  a_r10_flush: assert property (@(posedge clk) disable iff (!rstN)
    inValid && flushEn && (int'(inExp) < 1 - BIAS) |=>
      outUnderflow && outInexact && outWord[TOP:1] == '0);

  // R1: exact in-range inputs keep their exponent, no flags
  a_r1_exact: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inSig[2:0] == 3'b000 && inSig[FRAC_W+3] &&
    (int'(inExp) >= 1 - BIAS) && (int'(inExp) <= BIAS) |=>
      !outInexact && !outUnderflow && !outOverflow &&
      outWord[TOP:FRAC_W] == EXP_BITS'(int'($past(inExp)) + BIAS));

  // R4: no NaN encoding is ever produced
  a_r4_no_nan: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(outWord[TOP:FRAC_W] == EXP_ONES && outWord[FRAC_W-1:0] != '0));

endmodule

bind rp_round_pack rp_round_pack_chk #(
  .EXP_W(EXP_W), .EXP_BITS(EXP_BITS), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inExp(inExp), .inSig(inSig),
  .flushEn(flushEn), .outValid(outValid), .outWord(outWord),
  .outInexact(outInexact), .outUnderflow(outUnderflow), .outOverflow(outOverflow)
);

// File: tb/rp_round_pack_bench.sv
`timescale 1ns/1ps
module rp_round_pack_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inSign = 1'b0;
  logic signed [9:0] inExp = '0;
  logic [26:0] inSig = '0;
  logic [1:0] roundMode = '0;
  logic flushEn = 1'b0;
  logic outValid;
  logic [31:0] outWord;
  logic outInexact, outUnderflow, outOverflow;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rp_round_pack u_rp_round_pack (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSign(inSign), .inExp(inExp),
    .inSig(inSig), .roundMode(roundMode), .flushEn(flushEn),
    .outValid(outValid), .outWord(outWord), .outInexact(outInexact),
    .outUnderflow(outUnderflow), .outOverflow(outOverflow)
  );

  // increment rule of the rounding modes
  function automatic longint incOf(bit sn, longint m, int rm);
    if ((m & 7) == 0) return 0;
    case (rm)
      0: return ((m & 8) != 0) ? 4 : 3;
      2: return sn ? 0 : 8;
      3: return sn ? 8 : 0;
      default: return 0;
    endcase
  endfunction

  // reference: returns {ovf, unf, inx, word}
  function automatic logic [34:0] refModel(bit sn, int e, longint m, int rm, bit fl);
    bit inx, unf, ovf;
    logic [31:0] w;
    inx = 0; unf = 0; ovf = 0;
    if (e < -126 && fl) begin
      w = ((rm == 2 && !sn) || (rm == 3 && sn)) ? {sn, 31'd1} : {sn, 31'd0};
      return {1'b0, 1'b1, 1'b1, w};
    end
    if (e < -126) begin
      if (e == -127 && (m + incOf(sn, m, rm)) >= (longint'(1) << 27)) begin
        m = ((m + incOf(sn, m, rm)) >> 1) & ~longint'(7);
        inx = 1;
      end else begin
        int sh;
        sh = -126 - e;
        if (sh >= 27) m = (m != 0) ? 1 : 0;
        else m = (m >> sh) | (((m & ((longint'(1) << sh) - 1)) != 0) ? 1 : 0);
      end
      e = -126;
    end
    if ((m & 7) != 0) begin
      inx = 1;
      if (m < (longint'(1) << 26)) unf = 1;
      m = m + incOf(sn, m, rm);
      if (m >= (longint'(1) << 27)) begin
        m = m >> 1;
        e = e + 1;
      end
    end
    m = m >> 3;
    if (e > 127) begin
      ovf = 1; inx = 1; unf = 0;
      if (rm == 0 || (rm == 2 && !sn) || (rm == 3 && sn)) w = {sn, 8'hFF, 23'd0};
      else w = {sn, 8'hFE, 23'h7FFFFF};
    end else if (m < (longint'(1) << 23)) begin
      w = {sn, 8'd0, m[22:0]};
    end else begin
      w = {sn, 8'(e + 127), m[22:0]};
    end
    return {ovf, unf, inx, w};
  endfunction

  task automatic runCase(input string tag, input bit sn, input int e,
                         input logic [26:0] sig, input int rm, input bit fl,
                         input logic [31:0] expW, input logic [2:0] expF);
    @(negedge clk);
    inValid = 1'b1; inSign = sn; inExp = 10'(e); inSig = sig;
    roundMode = 2'(rm); flushEn = fl;
    @(negedge clk);
    inValid = 1'b0;
    checks++;
    if (!outValid || outWord !== expW ||
        {outOverflow, outUnderflow, outInexact} !== expF) begin
      fails++;
      $display("FAIL %s: sn=%0d e=%0d sig=%h rm=%0d fl=%0d got v=%0d w=%h f=%b exp w=%h f=%b",
               tag, sn, e, sig, rm, fl, outValid, outWord,
               {outOverflow, outUnderflow, outInexact}, expW, expF);
    end
  endtask

  task automatic runRef(input string tag, input bit sn, input int e,
                        input logic [26:0] sig, input int rm, input bit fl);
    logic [34:0] r;
    r = refModel(sn, e, longint'(sig), rm, fl);
    runCase(tag, sn, e, sig, rm, fl, r[31:0], r[34:32]);
  endtask

  task automatic testReset();
    checks++;
    if (outValid !== 1'b0 || outWord !== 32'd0 || outInexact || outUnderflow || outOverflow) begin
      fails++;
      $display("FAIL R11 reset: got v=%0d w=%h exp v=0 w=00000000", outValid, outWord);
    end
  endtask

  task automatic testIdle();
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R11 idle valid: got %0d exp 0", outValid);
    end
  endtask

  task automatic testExact();
    runCase("R1 exact", 0, 0, {1'b1, 23'h123456, 3'b000}, 0, 0, 32'h3F923456, 3'b000);
    runCase("R1 exact max", 1, 127, {1'b1, 23'h7FFFFF, 3'b000}, 1, 0, 32'hFF7FFFFF, 3'b000);
    runCase("R1 exact min", 0, -126, {1'b1, 23'h0, 3'b000}, 2, 0, 32'h00800000, 3'b000);
  endtask

  task automatic testNearest();
    runCase("R2 tie even stays", 0, 0, {1'b1, 23'h0, 3'b100}, 0, 0, 32'h3F800000, 3'b001);
    runCase("R2 tie odd up", 0, 0, {1'b1, 23'h1, 3'b100}, 0, 0, 32'h3F800002, 3'b001);
    runCase("R2 above half", 0, 0, {1'b1, 23'h0, 3'b101}, 0, 0, 32'h3F800001, 3'b001);
    runCase("R2 below half", 0, 0, {1'b1, 23'h0, 3'b011}, 0, 0, 32'h3F800000, 3'b001);
  endtask

  task automatic testDirected();
    runCase("R3 toward zero", 1, 0, {1'b1, 23'h0, 3'b001}, 1, 0, 32'hBF800000, 3'b001);
    runCase("R3 up negative", 1, 0, {1'b1, 23'h0, 3'b001}, 2, 0, 32'hBF800000, 3'b001);
    runCase("R3 down negative", 1, 0, {1'b1, 23'h0, 3'b001}, 3, 0, 32'hBF800001, 3'b001);
    runCase("R3 up positive", 0, 0, {1'b1, 23'h0, 3'b001}, 2, 0, 32'h3F800001, 3'b001);
    runCase("R3 down positive", 0, 0, {1'b1, 23'h0, 3'b001}, 3, 0, 32'h3F800000, 3'b001);
  endtask

  task automatic testCarry();
    runCase("R5 carry renorm", 0, 0, {1'b1, 23'h7FFFFF, 3'b100}, 0, 0, 32'h40000000, 3'b001);
    runCase("R5 carry up mode", 1, 5, {1'b1, 23'h7FFFFF, 3'b001}, 3, 0, 32'hC2800000, 3'b001);
  endtask

  task automatic testOverflow();
    runCase("R6 carry to inf", 0, 127, {1'b1, 23'h7FFFFF, 3'b111}, 0, 0, 32'h7F800000, 3'b101);
    runCase("R6 zero neg", 1, 128, {1'b1, 23'h0, 3'b000}, 1, 0, 32'hFF7FFFFF, 3'b101);
    runCase("R6 up pos", 0, 128, {1'b1, 23'h0, 3'b000}, 2, 0, 32'h7F800000, 3'b101);
    runCase("R6 up neg", 1, 128, {1'b1, 23'h0, 3'b000}, 2, 0, 32'hFF7FFFFF, 3'b101);
    runCase("R6 down pos", 0, 128, {1'b1, 23'h0, 3'b000}, 3, 0, 32'h7F7FFFFF, 3'b101);
    runCase("R6 down neg", 1, 128, {1'b1, 23'h0, 3'b000}, 3, 0, 32'hFF800000, 3'b101);
  endtask

  task automatic testDenorm();
    runCase("R7 exact subnormal", 0, -127, {1'b1, 23'h0, 3'b000}, 0, 0, 32'h00400000, 3'b000);
    runCase("R7 R8 sticky shift", 0, -130, {1'b1, 23'h0, 3'b001}, 0, 0, 32'h00080000, 3'b011);
    runCase("R7 R8 rounds to normal", 0, -127, {1'b1, 23'h7FFFFF, 3'b000}, 0, 0, 32'h00800000, 3'b011);
    runCase("R7 R8 deep shift", 1, -200, {1'b1, 23'h0, 3'b000}, 3, 0, 32'h80000001, 3'b011);
  endtask

  task automatic testBoundary();
    runCase("R9 not tiny", 0, -127, {1'b1, 23'h7FFFFF, 3'b100}, 0, 0, 32'h00800000, 3'b001);
    runCase("R9 up mode", 0, -127, {1'b1, 23'h7FFFFF, 3'b001}, 2, 0, 32'h00800000, 3'b001);
    runCase("R9 zero mode tiny", 0, -127, {1'b1, 23'h7FFFFF, 3'b100}, 1, 0, 32'h007FFFFF, 3'b011);
  endtask

  task automatic testFlush();
    runCase("R10 nearest", 0, -127, {1'b1, 23'h0, 3'b000}, 0, 1, 32'h00000000, 3'b011);
    runCase("R10 zero neg", 1, -140, {1'b1, 23'h0, 3'b000}, 1, 1, 32'h80000000, 3'b011);
    runCase("R10 up pos", 0, -127, {1'b1, 23'h0, 3'b000}, 2, 1, 32'h00000001, 3'b011);
    runCase("R10 up neg", 1, -127, {1'b1, 23'h0, 3'b000}, 2, 1, 32'h80000000, 3'b011);
    runCase("R10 down neg", 1, -127, {1'b1, 23'h0, 3'b000}, 3, 1, 32'h80000001, 3'b011);
    runCase("R10 down pos", 0, -127, {1'b1, 23'h7FFFFF, 3'b100}, 3, 1, 32'h00000000, 3'b011);
  endtask

  task automatic testSweep();
    int exps[6] = '{-150, -127, -126, 0, 127, 128};
    logic [26:0] sigs[6] = '{27'h7FFFFFF, 27'h7FFFFF8, 27'h7FFFFFC,
                             27'h4000004, 27'h400000C, 27'h4000001};
    for (int rm = 0; rm < 4; rm++)
      for (int ei = 0; ei < 6; ei++)
        for (int si = 0; si < 6; si++)
          for (int sn = 0; sn < 2; sn++)
            for (int fl = 0; fl < 2; fl++)
              runRef("R4 sweep", sn[0], exps[ei], sigs[si], rm, fl[0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    testExact();
    testNearest();
    testDirected();
    testCarry();
    testOverflow();
    testDenorm();
    testBoundary();
    testFlush();
    testIdle();
    testSweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule